// File: doc/BRIEF.md
# Staged Multi-Channel DAC Code Register Interface

This block is a write-only bus slave that feeds sixteen independent 12-bit converter code outputs from a host through two byte-wide locations. The first location holds the eight low code bits in a staging register. The second location packs the four upper code bits together with a channel number. Writing that second byte joins the nibble to the staged low byte and commits the full 12-bit code to the output register of the channel it names.

Each channel keeps its own output register and has its own update strobe. The strobe pulses for one cycle when that channel takes a new code, so the converter behind it can latch the value. The codes are unsigned straight binary. Code 0 is the bottom of the output range and 4095 is full scale. The block has no read path.

Top module: `dacw_regif`

## Requirements
- R1: A write with `wr_en`=1 and `wr_addr`=0 loads `wr_data` into the staging register. It changes no channel output and raises no update strobe.
- R2: A write with `wr_en`=1 and `wr_addr`=1 is a commit. It loads the code {`wr_data[3:0]`, staged byte} into the addressed channel's output. The new code appears on `code_o` from the clock edge that accepts the write.
- R3: The channel number is `wr_data[7:4]` in plain binary. 0000 selects channel 0, 0101 selects channel 5 and 1111 selects channel 15. Channel n occupies `code_o[12n+11:12n]`.
- R4: A commit changes only the addressed channel. Every other channel keeps its code.
- R5: `upd_o[n]` is high for exactly the one cycle after a commit to channel n is accepted, and it is low at all other times. At most one strobe bit is high in any cycle.
- R6: The staging register keeps its value through a commit. A second commit with no new offset-0 write in between reuses the previous low byte.
- R7: A synchronous active-low reset clears every channel output and the staging register to zero. No strobe is high while reset is held, even if writes are presented during it.
- R8: Bus activity with `wr_en`=0 changes no state and raises no strobe.
- R9: Codes pass bit-exact as unsigned binary across the full range, including 12'h000 and 12'hFFF.
- R10: An offset-0 write on one cycle followed by a commit on the very next cycle uses the newly written low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe; a write is accepted on each rising edge where it is high |
| wr_addr | input | 1 | Base-relative offset: 0 for the low code byte, 1 for the nibble and channel byte |
| wr_data | input | 8 | Write data byte |
| code_o | output | 192 | Sixteen 12-bit channel codes; channel n in bits 12n+11 to 12n |
| upd_o | output | 16 | One-cycle update strobe for each channel |

## Verification
The hardest case to reach from the ports is a commit whose low byte did not come from a preceding offset-0 write. One version uses a byte left in staging by an earlier commit, and another uses the zero left by reset. The stimulus reaches both directly. It commits twice in a row with only the channel and nibble changed, and it commits right after reset with no staging write at all. A back-to-back offset-0 and offset-1 pair on adjacent cycles exercises the ordering at the staging register. Offset-1 traffic held with the strobe low, and writes driven while reset is asserted, show that nothing leaks into the channel outputs.

// File: rtl/dacw_pkg.sv
// Package: dacw_pkg
// Shared constants and the register offset encoding for the DAC write interface.
// Assumes a single base-relative address bit selects between the two locations.
package dacw_pkg;

    // Host data bus width in bits.
    localparam int unsigned DACW_BYTE_W = 8;

    // Base-relative offsets of the two write-only locations.
    typedef enum logic {
        OFS_LOW_BYTE  = 1'b0,
        OFS_HIGH_CHAN = 1'b1
    } dacw_ofs_e;

endpackage

// File: rtl/dacw_stage.sv
// Module: dacw_stage
// Holds the low code byte written at offset 0 until a later write replaces it.
// Assumes synchronous active-low reset; a commit never touches this register.
module dacw_stage #(
    parameter int unsigned BYTE_W = dacw_pkg::DACW_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [BYTE_W-1:0] d_i,
    output logic [BYTE_W-1:0] q_o
);

    logic [BYTE_W-1:0] stage_q;

    // Load the staged byte on an offset-0 write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (ld_i) begin
            stage_q <= d_i;
        end
    end

    assign q_o = stage_q;

    // R1
    stage_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> stage_q == $past(d_i));

    // R6
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> $stable(stage_q));

endmodule

// File: rtl/dacw_decode.sv
// Module: dacw_decode
// Decodes a host write into a staging load or a one-hot channel commit. It also
// forms the 12-bit code from the written nibble and the staged low byte.
// Assumes the nibble sits in the low bits of the byte and the channel number in
// the bits above it (HI_W + CH_W must not exceed BYTE_W).
module dacw_decode #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned CODE_W = 12,
    parameter int unsigned BYTE_W = dacw_pkg::DACW_BYTE_W
) (
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] stage_i,
    output logic              ld_low_o,
    output logic [NUM_CH-1:0] sel_o,
    output logic [CODE_W-1:0] code_o
);

    import dacw_pkg::*;

    localparam int unsigned HI_W = CODE_W - BYTE_W;
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    dacw_ofs_e         ofs;
    logic              commit;
    logic [CH_W-1:0]   chan;
    logic [HI_W-1:0]   hi_nib;

    // Classify the write by its offset.
    always_comb begin
        ofs      = dacw_ofs_e'(wr_addr);
        ld_low_o = wr_en && (ofs == OFS_LOW_BYTE);
        commit   = wr_en && (ofs == OFS_HIGH_CHAN);
    end

    // Split the high byte into the code nibble and the channel number.
    always_comb begin
        hi_nib = wr_data[HI_W-1:0];
        chan   = wr_data[HI_W +: CH_W];
        code_o = {hi_nib, stage_i};
    end

    // One select line per channel, raised only on a commit to that channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign sel_o[g] = commit && (chan == CH_W'(g));
    end

endmodule

// File: rtl/dacw_bank.sv
// Module: dacw_bank
// One code register and one update-strobe flop per channel. A channel loads the
// shared code when its select line is high and pulses its strobe one cycle later.
// Assumes at most one select line is high per cycle.
module dacw_bank #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned CODE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        sel_i,
    input  logic [CODE_W-1:0]        code_i,
    output logic [NUM_CH*CODE_W-1:0] code_o,
    output logic [NUM_CH-1:0]        upd_o
);

    logic [CODE_W-1:0] code_q [NUM_CH];
    logic [NUM_CH-1:0] upd_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Load this channel's code on its commit, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q[g] <= '0;
            end else if (sel_i[g]) begin
                code_q[g] <= code_i;
            end
        end

        // Pulse this channel's strobe for the cycle after its commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                upd_q[g] <= 1'b0;
            end else begin
                upd_q[g] <= sel_i[g];
            end
        end

        assign code_o[g*CODE_W +: CODE_W] = code_q[g];

        // R2
        ch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sel_i[g] |=> code_q[g] == $past(code_i));

        // R4
        ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !sel_i[g] |=> $stable(code_q[g]));

        // R5
        upd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            upd_q[g] |-> $past(sel_i[g]));
    end

    assign upd_o = upd_q;

    // R5
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_q));

    // R7
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (upd_q == '0));

endmodule

// File: rtl/dacw_regif.sv
// Module: dacw_regif
// Top level of the staged DAC register interface. Offset 0 stages a low code
// byte; offset 1 carries the upper nibble and channel number and commits the
// joined code to that channel. Assumes a synchronous active-low reset and one
// write per cycle at most; there is no read path.
module dacw_regif #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned CODE_W = 12,
    parameter int unsigned BYTE_W = dacw_pkg::DACW_BYTE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_addr,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [NUM_CH*CODE_W-1:0] code_o,
    output logic [NUM_CH-1:0]        upd_o
);

    logic              ld_low;
    logic [BYTE_W-1:0] stage;
    logic [NUM_CH-1:0] sel;
    logic [CODE_W-1:0] new_code;

    dacw_decode #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W),
        .BYTE_W (BYTE_W)
    ) u_decode (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .stage_i  (stage),
        .ld_low_o (ld_low),
        .sel_o    (sel),
        .code_o   (new_code)
    );

    dacw_stage #(
        .BYTE_W (BYTE_W)
    ) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_i  (ld_low),
        .d_i   (wr_data),
        .q_o   (stage)
    );

    dacw_bank #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .code_i (new_code),
        .code_o (code_o),
        .upd_o  (upd_o)
    );

    // R1
    low_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> (upd_o == '0));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (upd_o == '0) && $stable(code_o));

endmodule

// File: tb/sim_dacw_regif.sv
`timescale 1ns/1ps
module sim_dacw_regif;

    localparam int NCH = 16;
    localparam int CW  = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic            wr_addr = 1'b0;
    logic [7:0]      wr_data = 8'h00;
    logic [NCH*CW-1:0] code_o;
    logic [NCH-1:0]  upd_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [CW-1:0] exp_code [NCH];
    logic [7:0]    exp_stage;

    always #2.5 clk = ~clk;

    dacw_regif u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .code_o  (code_o),
        .upd_o   (upd_o)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_codes(input string req);
        for (int i = 0; i < NCH; i++)
            check($sformatf("%s ch%0d", req, i), int'(code_o[i*CW +: CW]), int'(exp_code[i]));
    endtask

    // One bus write; returns at the negedge after the accepting edge.
    task automatic bus_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 1'b0) exp_stage = d;
        else exp_code[d[7:4]] = {d[3:0], exp_stage};
    endtask

    // Commit and check the strobe pulse and all channel codes.
    task automatic commit_chk(input string req, input logic [7:0] d);
        bus_wr(1'b1, d);
        check({req, " strobe"}, int'(upd_o), 1 << d[7:4]);
        check_codes(req);
        @(negedge clk);
        check({req, " strobe low"}, int'(upd_o), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h5A;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R7 no strobe in reset", int'(upd_o), 0);
        end
        wr_en = 1'b0;
        for (int i = 0; i < NCH; i++) exp_code[i] = '0;
        exp_stage = 8'h00;
        check_codes("R7 cleared");
        rst_n = 1'b1;
        // staging is zero: commit nibble 3 to ch0 gives 0x300
        commit_chk("R7 staging zero", 8'h03);
    endtask

    task automatic t_basic;
        bus_wr(1'b0, 8'hA5);
        check("R1 no strobe on low write", int'(upd_o), 0);
        check_codes("R1 low write no change");
        commit_chk("R2 commit ch5", 8'h5C);
        check("R2 ch5 code", int'(code_o[5*CW +: CW]), 12'hCA5);
    endtask

    task automatic t_channels;
        bus_wr(1'b0, 8'h11);
        commit_chk("R3 ch0", 8'h02);
        commit_chk("R3 ch15", 8'hF7);
        check("R3 ch15 position", int'(code_o[15*CW +: CW]), 12'h711);
        for (int c = 1; c < 15; c++) begin
            bus_wr(1'b0, 8'(c * 13));
            commit_chk("R4 walk", {4'(c), 4'(c ^ 4'h9)});
        end
    endtask

    task automatic t_reuse;
        bus_wr(1'b0, 8'h3C);
        commit_chk("R6 first", 8'h81);
        commit_chk("R6 reuse", 8'h9E);
        check("R6 reused low byte", int'(code_o[9*CW +: CW]), 12'hE3C);
    endtask

    task automatic t_idle;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 1'b1; wr_data = 8'h4F;
        @(negedge clk);
        check("R8 idle no strobe", int'(upd_o), 0);
        wr_addr = 1'b0; wr_data = 8'hEE;
        @(negedge clk);
        check_codes("R8 idle no change");
        commit_chk("R8 staging untouched", 8'h40);
        check("R8 ch4 keeps old low byte", int'(code_o[4*CW +: CW]), {4'h0, exp_stage});
    endtask

    task automatic t_back2back;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h77;
        @(negedge clk);
        wr_addr = 1'b1; wr_data = 8'hB2;
        @(negedge clk);
        wr_en = 1'b0;
        exp_stage = 8'h77;
        exp_code[11] = 12'h277;
        check("R10 b2b strobe", int'(upd_o), 1 << 11);
        check("R10 b2b code", int'(code_o[11*CW +: CW]), 12'h277);
    endtask

    task automatic t_bounds;
        bus_wr(1'b0, 8'hFF);
        commit_chk("R9 full scale", 8'h6F);
        check("R9 ch6 0xFFF", int'(code_o[6*CW +: CW]), 12'hFFF);
        bus_wr(1'b0, 8'h00);
        commit_chk("R9 zero", 8'h60);
        check("R9 ch6 0x000", int'(code_o[6*CW +: CW]), 12'h000);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_channels();
        t_reuse();
        t_idle();
        t_back2back();
        t_bounds();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule